// File: doc/BRIEF.md
# Host-Side PCI Bridge Address Decoder

This block sits between a host processor bus and the downstream side of a CPU-to-PCI bridge. It takes one host access at a time, sorts the 32-bit address into one of four windows, and either forwards the access to the matching downstream port or answers it locally. PCI I/O and PCI memory accesses travel downstream with their host address untouched. Configuration accesses are split into a slot number and a register offset. Two small control registers are serviced in place. Any address that maps to nothing ends with an error response, and so does a configuration access to a slot whose card-present input is low.

The data path can reverse the byte order of every forwarded word in both directions, so a big-endian host sees little-endian PCI data in its natural order. A control register selects this mode. A second control register gates a merged interrupt. The OR of all slot interrupt lines drives one level-sensitive host interrupt. No acknowledge register exists, so the host clears the interrupt at its source on the card.

The host request and response channels both use valid/ready. A request holds its address, direction and write data stable while `hreq_valid` is high and `hreq_ready` is low. The block keeps `hrsp_valid` and the response fields steady until `hrsp_ready` is seen high. It accepts no new request until that response has retired. Each downstream request port follows the same rule: it holds `dn_valid` and its payload until `dn_ready` is seen. The port then waits for a one-cycle `dn_rsp_valid` pulse on that same port.

Top module: `pbr_host_front`

## Requirements
- R1: A host address in 0xFFFA0000–0xFFFAFFFF goes to downstream port 0 (I/O), and one in 0x80000000–0xBFFFFFFF (the memory window, 2^MEM_BITS bytes) goes to port 2 (memory). In both cases `dn_addr` equals the host address unchanged, and read data returns on `hrsp_rdata` with `hrsp_err` low.
- R2: In the configuration window 0xFFFC0000–0xFFFDFFFF, let k = address bits [16:12]. For k from 1 to NSLOT, the access goes to port 1 with `dn_cfg_slot` = k−1, `dn_cfg_reg` = address bits [11:0], and `dn_addr` = those same 12 bits zero-extended. A value of k = 0 (offsets below 0x1000) is not a slot.
- R3: An address outside every window gets `hrsp_err` = 1 and `hrsp_rdata` = 0, with no downstream request. The error response is presented in the cycle after the request is accepted.
- R4: A configuration access whose k is 0, exceeds NSLOT, or names a slot whose `card_present` bit is 0 also ends with the error response of R3.
- R5: Control offset 0x000 (byte order) and offset 0x010 (interrupt enable) are 8-bit registers. Both reset to 0 and read back their last written value in bits [7:0], with the upper bits 0. Any other offset in 0xFFFE0000–0xFFFE0FFF is an error. A control access responds in the cycle after acceptance.
- R6: While bit 1 of the byte-order register is set, forwarded write data and returned read data have their four bytes reversed (byte 0 swaps with byte 3, and byte 1 with byte 2). Control register data is never reversed.
- R7: `host_irq` is a register loaded each cycle with the OR of all `slot_irq` lines ANDed with bit 0 of the enable register. It changes one cycle after its inputs, and nothing else clears it.
- R8: Only one access is outstanding at a time, and `hreq_ready` is low from acceptance until the response retires. `hrsp_valid` and the response fields hold while `hrsp_ready` is low. `dn_valid` and its payload hold while `dn_ready` is low. With a zero-wait downstream, a forwarded response appears three cycles after acceptance.
- R9: A forwarded write passes `hreq_wdata` (byte-reversed under R6) on `dn_wdata`. It completes on the port's `dn_rsp_valid` pulse with `hrsp_err` = 0 and `hrsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hreq_valid | input | 1 | Host request valid |
| hreq_ready | output | 1 | Block can accept a request |
| hreq_write | input | 1 | 1 = write, 0 = read |
| hreq_addr | input | 32 | Host byte address |
| hreq_wdata | input | 32 | Host write data |
| hrsp_valid | output | 1 | Response valid |
| hrsp_ready | input | 1 | Host takes the response |
| hrsp_err | output | 1 | Bus-error termination |
| hrsp_rdata | output | 32 | Read data |
| dn_valid | output | 3 | Request valid, one bit per port (0 I/O, 1 config, 2 memory) |
| dn_ready | input | 3 | Per-port request ready |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | 32 | Downstream address |
| dn_wdata | output | 32 | Downstream write data |
| dn_cfg_slot | output | SLW | Configuration slot index |
| dn_cfg_reg | output | 12 | Configuration register offset |
| dn_rsp_valid | input | 3 | Per-port response pulse |
| dn_rsp_rdata | input | 96 | Per-port read data, port i in bits [32i+31:32i] |
| card_present | input | NSLOT | Slot holds a card |
| slot_irq | input | NSLOT | Slot interrupt lines |
| host_irq | output | 1 | Merged host interrupt |

## Verification
A wrong window decode shows up at the ports in the first response cycle. It appears as an error where data was due, as a request on the wrong `dn_valid` bit, or as a changed `dn_addr`. A stuck state in the sequencer shows as `hreq_ready` staying low or a response dropping before `hrsp_ready`. The latency checks catch this within one to three cycles. A corrupted control register surfaces on the next forwarded word as reversed bytes, or on `host_irq` one cycle after a slot line moves.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int RW = 8;
  localparam int NPORT = 3;
  localparam int PSW = 2;

  localparam logic [AW-1:0] IO_BASE   = 32'hFFFA_0000;
  localparam logic [AW-1:0] CFG_BASE  = 32'hFFFC_0000;
  localparam logic [AW-1:0] CTRL_BASE = 32'hFFFE_0000;
  localparam logic [AW-1:0] MEM_BASE  = 32'h8000_0000;
  localparam int IO_BITS   = 16;
  localparam int CFG_BITS  = 17;
  localparam int CTRL_BITS = 12;
  localparam int STRIDE_BITS = 12;
  localparam int KW = CFG_BITS - STRIDE_BITS;

  localparam logic [CTRL_BITS-1:0] OFS_ORDER = 12'h000;
  localparam logic [CTRL_BITS-1:0] OFS_IRQEN = 12'h010;

  localparam logic [PSW-1:0] PORT_IO  = 2'd0;
  localparam logic [PSW-1:0] PORT_CFG = 2'd1;
  localparam logic [PSW-1:0] PORT_MEM = 2'd2;

  typedef enum logic [2:0] {WIN_NONE, WIN_IO, WIN_CFG, WIN_CTRL, WIN_MEM} win_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FWD, ST_WAIT, ST_RSP} st_e;
endpackage

// File: rtl/pbr_win_decode.sv
module pbr_win_decode
  import pbr_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int MEM_BITS = 30,
  localparam int SLW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [AW-1:0]        addr,
  input  logic [NSLOT-1:0]     card_present,
  output win_e                 win,
  output logic [SLW-1:0]       slot,
  output logic [STRIDE_BITS-1:0] creg,
  output logic [AW-1:0]        fwd_addr
);
  localparam logic [KW-1:0] NSLOT_K = KW'(NSLOT);

  logic hit_io, hit_cfg, hit_ctrl, hit_mem;
  logic [KW-1:0] kslot;
  logic [KW-1:0] kidx;
  logic [31:0]   pres_ext;
  logic          slot_ok;

  assign hit_io   = addr[AW-1:IO_BITS]   == IO_BASE[AW-1:IO_BITS];
  assign hit_cfg  = addr[AW-1:CFG_BITS]  == CFG_BASE[AW-1:CFG_BITS];
  assign hit_ctrl = addr[AW-1:CTRL_BITS] == CTRL_BASE[AW-1:CTRL_BITS];
  assign hit_mem  = addr[AW-1:MEM_BITS]  == MEM_BASE[AW-1:MEM_BITS];

  assign kslot    = addr[CFG_BITS-1:STRIDE_BITS];
  assign kidx     = kslot - KW'(1);
  assign pres_ext = 32'(card_present);
  assign slot_ok  = (kslot != '0) && (kslot <= NSLOT_K) && pres_ext[kidx];
  assign creg     = addr[STRIDE_BITS-1:0];

  always_comb begin
    win      = WIN_NONE;
    slot     = '0;
    fwd_addr = addr;
    if (hit_io) begin
      win = WIN_IO;
    end else if (hit_mem) begin
      win = WIN_MEM;
    end else if (hit_cfg) begin
      if (slot_ok) begin
        win      = WIN_CFG;
        slot     = SLW'(kidx);
        fwd_addr = AW'(addr[STRIDE_BITS-1:0]);
      end
    end else if (hit_ctrl) begin
      if (creg == OFS_ORDER || creg == OFS_IRQEN) win = WIN_CTRL;
    end
  end
endmodule

// File: rtl/pbr_lane_swap.sv
module pbr_lane_swap #(
  parameter int W = 32,
  localparam int NB = W / 8
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] rev;
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
  end
  assign dout = en ? rev : din;
endmodule

// File: rtl/pbr_ctrl_regs.sv
module pbr_ctrl_regs
  import pbr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel_irq,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] order_q,
  output logic [RW-1:0] irqen_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      order_q <= '0;
      irqen_q <= '0;
    end else if (we) begin
      if (sel_irq) irqen_q <= wdata;
      else         order_q <= wdata;
    end
  end
endmodule

// File: rtl/pbr_irq_merge.sv
module pbr_irq_merge #(
  parameter int NSLOT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] slot_irq,
  input  logic             en,
  output logic             host_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) host_irq <= 1'b0;
    else        host_irq <= en & (|slot_irq);
  end
endmodule

// File: rtl/pbr_host_front.sv
module pbr_host_front
  import pbr_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int MEM_BITS = 30,
  localparam int SLW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hreq_valid,
  output logic                 hreq_ready,
  input  logic                 hreq_write,
  input  logic [AW-1:0]        hreq_addr,
  input  logic [DW-1:0]        hreq_wdata,
  output logic                 hrsp_valid,
  input  logic                 hrsp_ready,
  output logic                 hrsp_err,
  output logic [DW-1:0]        hrsp_rdata,
  output logic [NPORT-1:0]     dn_valid,
  input  logic [NPORT-1:0]     dn_ready,
  output logic                 dn_write,
  output logic [AW-1:0]        dn_addr,
  output logic [DW-1:0]        dn_wdata,
  output logic [SLW-1:0]       dn_cfg_slot,
  output logic [STRIDE_BITS-1:0] dn_cfg_reg,
  input  logic [NPORT-1:0]     dn_rsp_valid,
  input  logic [NPORT*DW-1:0]  dn_rsp_rdata,
  input  logic [NSLOT-1:0]     card_present,
  input  logic [NSLOT-1:0]     slot_irq,
  output logic                 host_irq
);
  st_e                  st_q;
  logic [PSW-1:0]       sel_q;
  logic                 wr_q, err_q;
  logic [AW-1:0]        addr_q;
  logic [DW-1:0]        wdata_q, rdata_q;
  logic [SLW-1:0]       slot_q;
  logic [STRIDE_BITS-1:0] creg_q;

  win_e                 dec_win;
  logic [SLW-1:0]       dec_slot;
  logic [STRIDE_BITS-1:0] dec_creg;
  logic [AW-1:0]        dec_addr;
  logic [RW-1:0]        order_q, irqen_q;
  logic                 big_endian, irq_en_w;
  logic                 ctrl_we;
  logic [DW-1:0]        ctrl_rd, wdata_sw, rsp_word, rsp_sw;
  logic [NPORT-1:0]     sel_hot;
  logic [PSW-1:0]       dec_port;

  pbr_win_decode #(.NSLOT(NSLOT), .MEM_BITS(MEM_BITS)) u_dec (
    .addr(hreq_addr), .card_present(card_present), .win(dec_win),
    .slot(dec_slot), .creg(dec_creg), .fwd_addr(dec_addr));

  assign ctrl_we = (st_q == ST_IDLE) && hreq_valid && hreq_write && (dec_win == WIN_CTRL);

  pbr_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .sel_irq(dec_creg == OFS_IRQEN),
    .wdata(hreq_wdata[RW-1:0]), .order_q(order_q), .irqen_q(irqen_q));

  assign big_endian = order_q[1];
  assign irq_en_w   = irqen_q[0];
  assign ctrl_rd    = (dec_creg == OFS_IRQEN) ? DW'(irqen_q) : DW'(order_q);

  pbr_lane_swap #(.W(DW)) u_swap_w (.en(big_endian), .din(hreq_wdata), .dout(wdata_sw));
  pbr_lane_swap #(.W(DW)) u_swap_r (.en(big_endian), .din(rsp_word),   .dout(rsp_sw));

  pbr_irq_merge #(.NSLOT(NSLOT)) u_irq (
    .clk(clk), .rst_n(rst_n), .slot_irq(slot_irq), .en(irq_en_w), .host_irq(host_irq));

  always_comb begin
    case (dec_win)
      WIN_CFG: dec_port = PORT_CFG;
      WIN_MEM: dec_port = PORT_MEM;
      default: dec_port = PORT_IO;
    endcase
  end

  assign sel_hot = NPORT'(1) << sel_q;

  always_comb begin
    rsp_word = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (sel_q == PSW'(p)) rsp_word = dn_rsp_rdata[p*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sel_q   <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      slot_q  <= '0;
      creg_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (hreq_valid) begin
          wr_q <= hreq_write;
          case (dec_win)
            WIN_NONE: begin
              err_q   <= 1'b1;
              rdata_q <= '0;
              st_q    <= ST_RSP;
            end
            WIN_CTRL: begin
              err_q   <= 1'b0;
              rdata_q <= hreq_write ? '0 : ctrl_rd;
              st_q    <= ST_RSP;
            end
            default: begin
              err_q   <= 1'b0;
              sel_q   <= dec_port;
              addr_q  <= dec_addr;
              wdata_q <= wdata_sw;
              slot_q  <= dec_slot;
              creg_q  <= dec_creg;
              st_q    <= ST_FWD;
            end
          endcase
        end
        ST_FWD: if (|(dn_ready & sel_hot)) st_q <= ST_WAIT;
        ST_WAIT: if (|(dn_rsp_valid & sel_hot)) begin
          rdata_q <= wr_q ? '0 : rsp_sw;
          st_q    <= ST_RSP;
        end
        ST_RSP: if (hrsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign hreq_ready  = (st_q == ST_IDLE);
  assign hrsp_valid  = (st_q == ST_RSP);
  assign hrsp_err    = err_q;
  assign hrsp_rdata  = rdata_q;
  assign dn_valid    = (st_q == ST_FWD) ? sel_hot : '0;
  assign dn_write    = wr_q;
  assign dn_addr     = addr_q;
  assign dn_wdata    = wdata_q;
  assign dn_cfg_slot = slot_q;
  assign dn_cfg_reg  = creg_q;
endmodule

// File: rtl/pbr_host_front_chk.sv
module pbr_host_front_chk
  import pbr_pkg::*;
#(
  parameter int NSLOT = 4,
  localparam int SLW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hreq_ready,
  input logic               hrsp_valid,
  input logic               hrsp_ready,
  input logic               hrsp_err,
  input logic [DW-1:0]      hrsp_rdata,
  input logic [NPORT-1:0]   dn_valid,
  input logic [NPORT-1:0]   dn_ready,
  input logic [AW-1:0]      dn_addr,
  input logic [DW-1:0]      dn_wdata,
  input logic [SLW-1:0]     dn_cfg_slot,
  input logic [NSLOT-1:0]   slot_irq,
  input logic               irq_en_w,
  input logic               host_irq
);
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hrsp_valid && !hrsp_ready |=> hrsp_valid && $stable(hrsp_rdata) && $stable(hrsp_err));

  a_r8_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dn_valid & ~dn_ready)) |=> $stable(dn_valid) && $stable(dn_addr) && $stable(dn_wdata));

  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    (hrsp_valid || (|dn_valid)) |-> !hreq_ready);

  a_r1_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_valid));

  a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid[1] |-> (int'(dn_cfg_slot) < NSLOT));

  a_r3_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hrsp_valid && hrsp_err |-> hrsp_rdata == '0);

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(irq_en_w) && $past(|slot_irq));
endmodule

bind pbr_host_front pbr_host_front_chk #(.NSLOT(NSLOT)) u_chk (.*);

// File: tb/pbr_host_front_test.sv
`timescale 1ns/1ps
module pbr_host_front_test;
  localparam int NSLOT = 4;
  localparam logic [31:0] K = 32'h1234_5678;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hreq_valid = 1'b0, hreq_write = 1'b0, hrsp_ready = 1'b1;
  logic [31:0] hreq_addr = '0, hreq_wdata = '0;
  logic hreq_ready, hrsp_valid, hrsp_err;
  logic [31:0] hrsp_rdata;
  logic [2:0] dn_valid, dn_ready = 3'b111, dn_rsp_valid;
  logic dn_write;
  logic [31:0] dn_addr, dn_wdata;
  logic [1:0] dn_cfg_slot;
  logic [11:0] dn_cfg_reg;
  logic [31:0] rsp_word;
  logic [NSLOT-1:0] card_present = 4'b0101, slot_irq = '0;
  logic host_irq;

  int nchk = 0, nfail = 0, dn_hits = 0;
  logic [1:0] seen_port, seen_slot;
  logic [31:0] seen_addr, seen_wdata;
  logic [11:0] seen_reg;
  bit done = 0;

  always #2.5 clk = ~clk;

  pbr_host_front #(.NSLOT(NSLOT)) uut (
    .clk(clk), .rst_n(rst_n), .hreq_valid(hreq_valid), .hreq_ready(hreq_ready),
    .hreq_write(hreq_write), .hreq_addr(hreq_addr), .hreq_wdata(hreq_wdata),
    .hrsp_valid(hrsp_valid), .hrsp_ready(hrsp_ready), .hrsp_err(hrsp_err),
    .hrsp_rdata(hrsp_rdata), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_cfg_slot(dn_cfg_slot), .dn_cfg_reg(dn_cfg_reg), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_rdata({3{rsp_word}}), .card_present(card_present),
    .slot_irq(slot_irq), .host_irq(host_irq));

  // zero-wait downstream model: answers with address XOR K one cycle after handshake
  always @(posedge clk) begin
    if (!rst_n) begin
      dn_rsp_valid <= '0;
      rsp_word <= '0;
    end else begin
      dn_rsp_valid <= dn_valid & dn_ready;
      if (|(dn_valid & dn_ready)) begin
        seen_port  <= dn_valid[0] ? 2'd0 : (dn_valid[1] ? 2'd1 : 2'd2);
        seen_addr  <= dn_addr;
        seen_wdata <= dn_wdata;
        seen_slot  <= dn_cfg_slot;
        seen_reg   <= dn_cfg_reg;
        rsp_word   <= dn_addr ^ K;
        dn_hits    <= dn_hits + 1;
      end
    end
  end

  function automatic logic [31:0] rev4(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at a negedge after the response retires
  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                        output logic err, output logic [31:0] rd, output int lat);
    hreq_valid = 1'b1; hreq_write = wr; hreq_addr = a; hreq_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    hreq_valid = 1'b0;
    lat = 1;
    while (!hrsp_valid) begin @(negedge clk); lat++; end
    err = hrsp_err; rd = hrsp_rdata;
    @(posedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic wr; logic [31:0] addr; logic [31:0] wdata;
    logic [1:0] port; logic [31:0] daddr; logic [1:0] slot;
  } vec_t;
  // port 3 means an error response is expected (R3, R4)
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'hFFFA_0010, 32'h0,         2'd0, 32'hFFFA_0010, 2'd0},
    '{1'b1, 32'hFFFA_FFFC, 32'hA1B2_C3D4, 2'd0, 32'hFFFA_FFFC, 2'd0},
    '{1'b0, 32'h8000_0000, 32'h0,         2'd2, 32'h8000_0000, 2'd0},
    '{1'b0, 32'hBFFF_FFFC, 32'h0,         2'd2, 32'hBFFF_FFFC, 2'd0},
    '{1'b0, 32'hC000_0000, 32'h0,         2'd3, 32'h0,         2'd0},
    '{1'b0, 32'hFFFB_0000, 32'h0,         2'd3, 32'h0,         2'd0},
    '{1'b0, 32'hFFFC_0000, 32'h0,         2'd3, 32'h0,         2'd0},
    '{1'b0, 32'hFFFC_1008, 32'h0,         2'd1, 32'h0000_0008, 2'd0},
    '{1'b0, 32'hFFFC_2000, 32'h0,         2'd3, 32'h0,         2'd0},
    '{1'b1, 32'hFFFC_3FFC, 32'h0BAD_F00D, 2'd1, 32'h0000_0FFC, 2'd2},
    '{1'b0, 32'hFFFC_5000, 32'h0,         2'd3, 32'h0,         2'd0},
    '{1'b0, 32'hFFFE_0020, 32'h0,         2'd3, 32'h0,         2'd0},
    '{1'b0, 32'hFFFE_1000, 32'h0,         2'd3, 32'h0,         2'd0},
    '{1'b0, 32'h0000_1000, 32'h0,         2'd3, 32'h0,         2'd0},
    '{1'b1, 32'hFFFF_0000, 32'h5,         2'd3, 32'h0,         2'd0}
  };

  initial begin
    logic e; logic [31:0] rd; int lat; int h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R8 reset ready", 32'(hreq_ready), 32'd1);
    chk("R8 reset rsp", 32'(hrsp_valid), 32'd0);
    chk("R8 reset dn", 32'(dn_valid), 32'd0);
    chk("R7 reset irq", 32'(host_irq), 32'd0);
    access(1'b0, 32'hFFFE_0000, 32'h0, e, rd, lat);
    chk("R5 order reset", rd, 32'h0);
    chk("R5 ctrl latency", 32'(lat), 32'd1);
    access(1'b0, 32'hFFFE_0010, 32'h0, e, rd, lat);
    chk("R5 irqen reset", rd, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      h0 = dn_hits;
      access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, e, rd, lat);
      if (VECS[i].port == 2'd3) begin
        chk("R3/R4 err", 32'(e), 32'd1);
        chk("R3/R4 data", rd, 32'h0);
        chk("R3/R4 no downstream", 32'(dn_hits - h0), 32'd0);
        chk("R3 latency", 32'(lat), 32'd1);
      end else begin
        chk("R1 err", 32'(e), 32'd0);
        chk("R1 port", 32'(seen_port), 32'(VECS[i].port));
        chk("R1 addr", seen_addr, VECS[i].daddr);
        chk("R8 latency", 32'(lat), 32'd3);
        if (VECS[i].wr) begin
          chk("R9 wdata", seen_wdata, VECS[i].wdata);
          chk("R9 rdata", rd, 32'h0);
        end else begin
          chk("R1 rdata", rd, VECS[i].daddr ^ K);
        end
        if (VECS[i].port == 2'd1) begin
          chk("R2 slot", 32'(seen_slot), 32'(VECS[i].slot));
          chk("R2 reg", 32'(seen_reg), 32'(VECS[i].daddr[11:0]));
        end
      end
    end

    // control registers and byte order
    access(1'b1, 32'hFFFE_0000, 32'hFFFF_FF02, e, rd, lat);
    chk("R5 write err", 32'(e), 32'd0);
    access(1'b0, 32'hFFFE_0000, 32'h0, e, rd, lat);
    chk("R5/R6 order readback unswapped", rd, 32'h0000_0002);
    access(1'b1, 32'hFFFA_0040, 32'h1122_3344, e, rd, lat);
    chk("R6 write swapped", seen_wdata, 32'h4433_2211);
    access(1'b0, 32'h8000_0010, 32'h0, e, rd, lat);
    chk("R6 read swapped", rd, rev4(32'h8000_0010 ^ K));
    access(1'b1, 32'hFFFE_0000, 32'h0, e, rd, lat);
    access(1'b0, 32'h8000_0010, 32'h0, e, rd, lat);
    chk("R6 little again", rd, 32'h8000_0010 ^ K);

    // interrupt merge
    slot_irq = 4'b0100;
    @(negedge clk);
    chk("R7 disabled", 32'(host_irq), 32'd0);
    access(1'b1, 32'hFFFE_0010, 32'h0000_0001, e, rd, lat);
    access(1'b0, 32'hFFFE_0010, 32'h0, e, rd, lat);
    chk("R5 irqen readback", rd, 32'h1);
    chk("R7 enabled", 32'(host_irq), 32'd1);
    slot_irq = 4'b0000;
    chk("R7 latency hold", 32'(host_irq), 32'd1);
    @(negedge clk);
    chk("R7 drop", 32'(host_irq), 32'd0);
    slot_irq = 4'b1001;
    @(negedge clk);
    chk("R7 multi", 32'(host_irq), 32'd1);
    access(1'b1, 32'hFFFE_0010, 32'h0, e, rd, lat);
    chk("R7 cleared by enable", 32'(host_irq), 32'd0);
    slot_irq = '0;

    // downstream back-pressure then host back-pressure
    dn_ready = 3'b000;
    hreq_valid = 1'b1; hreq_write = 1'b0; hreq_addr = 32'hFFFA_0100;
    @(posedge clk);
    @(negedge clk);
    hreq_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      chk("R8 dn hold", 32'(dn_valid), 32'b001);
      chk("R8 busy", 32'(hreq_ready), 32'd0);
      @(negedge clk);
    end
    dn_ready = 3'b111;
    hrsp_ready = 1'b0;
    while (!hrsp_valid) @(negedge clk);
    chk("R8 data", hrsp_rdata, 32'hFFFA_0100 ^ K);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R8 rsp hold", 32'(hrsp_valid), 32'd1);
      chk("R8 rsp data hold", hrsp_rdata, 32'hFFFA_0100 ^ K);
    end
    hrsp_ready = 1'b1;
    @(negedge clk);
    chk("R8 retired", 32'(hrsp_valid), 32'd0);
    chk("R8 ready again", 32'(hreq_ready), 32'd1);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule